// File: doc/BRIEF.md
# Dual-Order Arithmetic and Logic Unit with Compare Flags

This block is a single-stage, 16-bit arithmetic and logic unit. Each accepted operation carries two operands, a 4-bit operation code and the current value of a flags register. One registered cycle later it returns three things: a result word, a write-enable for the result destination, and the new flags word. Every arithmetic result wraps modulo 2^16.

Shift-left, shift-right and subtract each have a reversed form. The reversed form swaps the roles of the two operands, so a shift can take its amount from the first operand and a subtraction can take the first operand as the subtrahend. The compare operation writes no result. It only rewrites three flag bits: equal, unsigned-below and signed-less-than. All other bits of the flags word pass through unchanged.

Operations enter through a valid/ready handshake and leave through another. A transfer happens on a rising edge where valid and ready are both high. The output stage holds one operation. It accepts a new operation when it is empty, or when its held operation is being taken in the same cycle. While the output is offered and not taken, result, write-enable and flags stay constant and the input is not ready.

Top module: `dual_order_alu`

## Requirements
- R1: Operation codes 0, 1 and 2 give op1 OR op2, op1 AND op2 and op1 XOR op2, with result write-enable 1.
- R2: Code 3 gives op1 shifted left by op2, and code 4 gives op2 shifted left by op1. A shift amount of 16 or more yields 0.
- R3: Code 5 gives op1 shifted right logically by op2, and code 6 gives op2 shifted right logically by op1. Zeros fill from the top, and an amount of 16 or more yields 0.
- R4: Code 7 gives op1+op2, code 8 gives op1-op2 and code 9 gives op2-op1, each modulo 2^16.
- R5: Code 10 (compare) sets flag bit EQ (default bit 1) when op1 equals op2, and clears it otherwise.
- R6: Compare sets flag bit BE (default bit 2) when op1 is below op2 as unsigned values, and clears it otherwise.
- R7: Compare sets flag bit LT (default bit 3) when op1 is less than op2 as signed 16-bit values, and clears it otherwise.
- R8: Compare leaves every other flag bit equal to the incoming flags, gives result write-enable 0 and result 0. Every non-compare code returns the incoming flags unchanged.
- R9: in_ready is high when out_valid is low or out_ready is high. An accepted operation appears on the outputs with out_valid high one cycle later. While out_valid is high and out_ready is low, result, res_we and flags_out hold.
- R10: After reset, out_valid is 0 and in_ready is 1.
- R11: Codes 11 to 15 give result 0, write-enable 0 and the incoming flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op | input | 4 | Operation code |
| op1 | input | 16 | First operand |
| op2 | input | 16 | Second operand |
| flags_in | input | 16 | Current flags register value |
| out_valid | output | 1 | Result offered |
| out_ready | input | 1 | Consumer takes the result |
| result | output | 16 | Operation result |
| res_we | output | 1 | Result should be written (0 for compare and for unused codes) |
| flags_out | output | 16 | New flags register value |

## Verification
The output stage can hand over a held result and capture the next operation on the same rising edge. The bench provokes this by stalling the consumer with a sum held at the output, keeping a subtraction offered on the input, and then raising out_ready. It judges the case by three observations: the sum stays stable and in_ready stays low during the stall, the subtraction's result appears exactly one cycle after the release, and the stage empties afterwards.

// File: rtl/dalu_pkg.sv
package dalu_pkg;
  typedef enum logic [3:0] {
    OP_OR   = 4'd0,
    OP_AND  = 4'd1,
    OP_XOR  = 4'd2,
    OP_SHL  = 4'd3,
    OP_RSHL = 4'd4,
    OP_SHR  = 4'd5,
    OP_RSHR = 4'd6,
    OP_ADD  = 4'd7,
    OP_SUB  = 4'd8,
    OP_RSUB = 4'd9,
    OP_CMP  = 4'd10
  } alu_op_e;
endpackage

// File: rtl/dalu_shift.sv
module dalu_shift #(
  parameter int W = 16
) (
  input  logic [W-1:0] val,
  input  logic [W-1:0] amt,
  input  logic         to_right,
  output logic [W-1:0] out
);
  localparam int SW = $clog2(W);
  localparam logic [W-1:0] LIMIT = W[W-1:0];

  logic too_far;
  assign too_far = (amt >= LIMIT);

  always_comb begin
    if (too_far)       out = '0;
    else if (to_right) out = val >> amt[SW-1:0];
    else               out = val << amt[SW-1:0];
  end
endmodule

// File: rtl/dalu_cmp.sv
module dalu_cmp #(
  parameter int W      = 16,
  parameter int FW     = 16,
  parameter int EQ_BIT = 1,
  parameter int BE_BIT = 2,
  parameter int LT_BIT = 3
) (
  input  logic [W-1:0]  a,
  input  logic [W-1:0]  b,
  input  logic [FW-1:0] flags_in,
  output logic [FW-1:0] flags_out
);
  logic eq, below, less;
  assign eq    = (a == b);
  assign below = (a < b);
  assign less  = ($signed(a) < $signed(b));

  always_comb begin
    flags_out         = flags_in;
    flags_out[EQ_BIT] = eq;
    flags_out[BE_BIT] = below;
    flags_out[LT_BIT] = less;
  end
endmodule

// File: rtl/dalu_stage.sv
module dalu_stage #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_data
);
  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) out_data <= in_data;
    end
  end
endmodule

// File: rtl/dual_order_alu.sv
module dual_order_alu
  import dalu_pkg::*;
#(
  parameter int W      = 16,
  parameter int FW     = 16,
  parameter int EQ_BIT = 1,
  parameter int BE_BIT = 2,
  parameter int LT_BIT = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [3:0]    op,
  input  logic [W-1:0]  op1,
  input  logic [W-1:0]  op2,
  input  logic [FW-1:0] flags_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [W-1:0]  result,
  output logic          res_we,
  output logic [FW-1:0] flags_out
);
  localparam int DW = W + 1 + FW;

  alu_op_e code;
  assign code = alu_op_e'(op);

  // Reversed forms swap operand roles before the shared datapath.
  logic reversed, subtract, to_right;
  logic [W-1:0] x, y, y_m, sum, shifted;
  logic [FW-1:0] cmp_flags;

  assign reversed = (code == OP_RSHL) || (code == OP_RSHR) || (code == OP_RSUB);
  assign subtract = (code == OP_SUB)  || (code == OP_RSUB);
  assign to_right = (code == OP_SHR)  || (code == OP_RSHR);
  assign x   = reversed ? op2 : op1;
  assign y   = reversed ? op1 : op2;
  assign y_m = subtract ? ~y : y;
  assign sum = x + y_m + {{(W-1){1'b0}}, subtract};

  dalu_shift #(.W(W)) u_shift (
    .val(x), .amt(y), .to_right(to_right), .out(shifted)
  );

  dalu_cmp #(
    .W(W), .FW(FW), .EQ_BIT(EQ_BIT), .BE_BIT(BE_BIT), .LT_BIT(LT_BIT)
  ) u_cmp (
    .a(op1), .b(op2), .flags_in(flags_in), .flags_out(cmp_flags)
  );

  logic [W-1:0]  nxt_res;
  logic          nxt_we;
  logic [FW-1:0] nxt_flags;

  always_comb begin
    nxt_res   = '0;
    nxt_we    = 1'b1;
    nxt_flags = flags_in;
    case (code)
      OP_OR:                    nxt_res = op1 | op2;
      OP_AND:                   nxt_res = op1 & op2;
      OP_XOR:                   nxt_res = op1 ^ op2;
      OP_SHL, OP_RSHL,
      OP_SHR, OP_RSHR:          nxt_res = shifted;
      OP_ADD, OP_SUB, OP_RSUB:  nxt_res = sum;
      OP_CMP: begin
        nxt_we    = 1'b0;
        nxt_flags = cmp_flags;
      end
      default:                  nxt_we = 1'b0;
    endcase
  end

  logic [DW-1:0] stage_in, stage_out;
  assign stage_in = {nxt_res, nxt_we, nxt_flags};

  dalu_stage #(.DW(DW)) u_stage (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(stage_in),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(stage_out)
  );

  assign result    = stage_out[DW-1 -: W];
  assign res_we    = stage_out[FW];
  assign flags_out = stage_out[FW-1:0];
endmodule

// File: rtl/dalu_checker.sv
module dalu_checker
  import dalu_pkg::*;
#(
  parameter int W      = 16,
  parameter int FW     = 16,
  parameter int EQ_BIT = 1,
  parameter int BE_BIT = 2,
  parameter int LT_BIT = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [3:0]    op,
  input logic [W-1:0]  op1,
  input logic [W-1:0]  op2,
  input logic [FW-1:0] flags_in,
  input logic          out_valid,
  input logic          out_ready,
  input logic [W-1:0]  result,
  input logic          res_we,
  input logic [FW-1:0] flags_out
);
  logic take;
  assign take = in_valid && in_ready;

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> !out_valid); // R10
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(result) && $stable(res_we) && $stable(flags_out)); // R9
  AST_ACCEPT_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R9
  AST_ADD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_ADD |=> result == W'($past(op1) + $past(op2))); // R4
  AST_EQ_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_CMP |=> flags_out[EQ_BIT] == ($past(op1) == $past(op2))); // R5
  AST_BE_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_CMP |=> flags_out[BE_BIT] == ($past(op1) < $past(op2))); // R6
  AST_LT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_CMP |=> flags_out[LT_BIT] == ($signed($past(op1)) < $signed($past(op2)))); // R7
  AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    take && op == OP_CMP |=> !res_we); // R8
  AST_FLAGS_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    take && op != OP_CMP |=> flags_out == $past(flags_in)); // R8
  AST_UNUSED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    take && op > OP_CMP |=> !res_we && result == '0); // R11
endmodule

bind dual_order_alu dalu_checker #(
  .W(W), .FW(FW), .EQ_BIT(EQ_BIT), .BE_BIT(BE_BIT), .LT_BIT(LT_BIT)
) u_chk (.*);

// File: tb/sim_dual_order_alu.sv
module sim_dual_order_alu;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 18;

  // {req, op, op1, op2, flags_in, result, res_we, flags_out}
  localparam logic [88:0] VEC [NV] = '{
    {4'd1,  4'd0,  16'h00F0, 16'h0F0F, 16'h0000, 16'h0FFF, 1'b1, 16'h0000}, // R1 or
    {4'd1,  4'd1,  16'hFF00, 16'h0FF0, 16'h0000, 16'h0F00, 1'b1, 16'h0000}, // R1 and
    {4'd1,  4'd2,  16'hAAAA, 16'hFFFF, 16'h0000, 16'h5555, 1'b1, 16'h0000}, // R1 xor
    {4'd2,  4'd3,  16'h0003, 16'h0004, 16'h0000, 16'h0030, 1'b1, 16'h0000}, // R2 shl
    {4'd2,  4'd4,  16'h0001, 16'h8001, 16'h0000, 16'h0002, 1'b1, 16'h0000}, // R2 reversed
    {4'd2,  4'd3,  16'hFFFF, 16'h0010, 16'h0000, 16'h0000, 1'b1, 16'h0000}, // R2 amount 16
    {4'd3,  4'd5,  16'h8000, 16'h000F, 16'h0000, 16'h0001, 1'b1, 16'h0000}, // R3 logical
    {4'd3,  4'd6,  16'h0004, 16'hF000, 16'h0000, 16'h0F00, 1'b1, 16'h0000}, // R3 reversed
    {4'd3,  4'd6,  16'h0020, 16'hFFFF, 16'h0000, 16'h0000, 1'b1, 16'h0000}, // R3 amount 32
    {4'd4,  4'd7,  16'hFFFF, 16'h0002, 16'h0000, 16'h0001, 1'b1, 16'h0000}, // R4 add wrap
    {4'd4,  4'd8,  16'h0001, 16'h0002, 16'h0000, 16'hFFFF, 1'b1, 16'h0000}, // R4 sub wrap
    {4'd4,  4'd9,  16'h0010, 16'h0001, 16'h0000, 16'hFFF1, 1'b1, 16'h0000}, // R4 reversed sub
    {4'd5,  4'd10, 16'h0005, 16'h0005, 16'hFFF1, 16'h0000, 1'b0, 16'hFFF3}, // R5 equal, R8 others kept
    {4'd6,  4'd10, 16'h0001, 16'hFFFF, 16'h000E, 16'h0000, 1'b0, 16'h0004}, // R6 below only
    {4'd7,  4'd10, 16'hFFFF, 16'h0001, 16'h0001, 16'h0000, 1'b0, 16'h0009}, // R7 signed less
    {4'd7,  4'd10, 16'h8000, 16'h7FFF, 16'h0000, 16'h0000, 1'b0, 16'h0008}, // R7 most negative
    {4'd8,  4'd7,  16'h1234, 16'h1111, 16'hBEEF, 16'h2345, 1'b1, 16'hBEEF}, // R8 flags pass
    {4'd11, 4'd12, 16'h1234, 16'h0001, 16'h00AA, 16'h0000, 1'b0, 16'h00AA}  // R11 unused code
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic in_ready, out_valid, res_we;
  logic [3:0]  op = '0;
  logic [15:0] op1 = '0, op2 = '0, flags_in = '0, result, flags_out;
  int n_chk = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_order_alu u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .op(op), .op1(op1), .op2(op2), .flags_in(flags_in),
    .out_valid(out_valid), .out_ready(out_ready),
    .result(result), .res_we(res_we), .flags_out(flags_out)
  );

  task automatic check(string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", what, act, exp);
    end
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R10 out_valid after reset", {31'd0, out_valid}, 32'd0);
    check("R10 in_ready after reset", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      op = VEC[i][84:81]; op1 = VEC[i][80:65]; op2 = VEC[i][64:49];
      flags_in = VEC[i][48:33]; in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check($sformatf("R%0d vec %0d valid", VEC[i][88:85], i), {31'd0, out_valid}, 32'd1);
      check($sformatf("R%0d vec %0d result", VEC[i][88:85], i), {16'd0, result}, {16'd0, VEC[i][32:17]});
      check($sformatf("R%0d vec %0d we", VEC[i][88:85], i), {31'd0, res_we}, {31'd0, VEC[i][16]});
      check($sformatf("R%0d vec %0d flags", VEC[i][88:85], i), {16'd0, flags_out}, {16'd0, VEC[i][15:0]});
    end

    // R9: stall with a held sum, then drain and accept on the same edge
    @(negedge clk);
    check("R9 idle after drain", {31'd0, out_valid}, 32'd0);
    out_ready = 1'b0;
    op = 4'd7; op1 = 16'd1; op2 = 16'd2; flags_in = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    op = 4'd8; op1 = 16'd9; op2 = 16'd4;
    check("R9 held valid", {31'd0, out_valid}, 32'd1);
    check("R9 not ready while stalled", {31'd0, in_ready}, 32'd0);
    check("R9 held sum", {16'd0, result}, 32'd3);
    repeat (2) @(negedge clk);
    check("R9 sum stable in stall", {16'd0, result}, 32'd3);
    check("R9 still not ready", {31'd0, in_ready}, 32'd0);
    out_ready = 1'b1;
    #1;
    check("R9 ready when taken", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 next result after same-edge hand-over", {16'd0, result}, 32'd5);
    check("R9 valid after hand-over", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R9 empty after drain", {31'd0, out_valid}, 32'd0);

    // R10: reset in the middle of traffic
    in_valid = 1'b1; op = 4'd0; op1 = 16'h1; op2 = 16'h2;
    @(negedge clk);
    in_valid = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R10 mid-run reset clears valid", {31'd0, out_valid}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    check("R10 ready in reset", {31'd0, in_ready}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule